// File: doc/BRIEF.md
# Modem Status Delta Tracker

This block holds the modem status byte of a serial port. Four incoming status lines (carrier detect, ring, data-set ready and clear-to-send) pass through a resynchronizer. Each settled level is compared with the level the block last recorded. Any movement sets a sticky change flag, and the flag stays set until software reads the byte. The ring line is treated differently from the other three. Its flag marks only the end of a ring, when the line drops from 1 to 0.

A one-cycle read strobe returns the status byte combinationally in the cycle the strobe is high. The change flags clear at the following clock edge. A change detected in that same cycle still leaves its flag set, so no event is lost. The OR of the change flags is brought out as a level for the interrupt logic.

In loopback mode the byte is built from the modem control outputs and the external lines are ignored. A diagnostic routine can then check the path without a cable.

Top module: `modem_status_tracker`

## Requirements
- R1: After a synchronous reset, with loopback off and the lines at their idle values, the read byte is 0xB0: carrier detect, data-set ready and clear-to-send high, ring low, no change flags set. The any-change output is 0.
- R2: Outside loopback, bits 7, 6, 5 and 4 of the read byte carry the recorded levels of carrier detect, ring, data-set ready and clear-to-send. Bits 3, 2, 1 and 0 carry their change flags in the same order.
- R3: Each external line goes through a two-stage synchronizer. A line that changes before clock edge E first appears in the read byte after edge E+2.
- R4: Any change of carrier detect, data-set ready or clear-to-send sets its change flag (bit 3, 1 or 0). The flag stays set through later cycles without a read, even if the line returns to its old value.
- R5: The ring change flag (bit 2) sets only when the recorded ring level goes from 1 to 0. A 0 to 1 transition leaves it clear.
- R6: A read strobe outside loopback returns the current byte with its flags in that cycle. All four flags are clear after the next edge, unless R7 applies.
- R7: When a change is detected in the same cycle as a read strobe, that change's flag is set after the edge.
- R8: Modem control input bits are: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback enable. In loopback the read byte is {OUT2, OUT1, DTR, RTS, 4'b0000}.
- R9: In loopback the external lines and the read strobe have no effect on the recorded levels or flags. After loopback ends, a line whose settled value differs from the recorded level raises its flag.
- R10: The any-change output equals the OR of the four stored change flags at all times, including during loopback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mctl_i | input | 5 | Modem control register value (DTR, RTS, OUT1, OUT2, loopback) |
| line_cts_i | input | 1 | External clear-to-send line, asynchronous |
| line_dsr_i | input | 1 | External data-set ready line, asynchronous |
| line_dcd_i | input | 1 | External carrier detect line, asynchronous |
| line_ri_i | input | 1 | External ring line, asynchronous |
| rd_stb_i | input | 1 | One-cycle read strobe for the status byte |
| rd_data_o | output | 8 | Status byte |
| delta_any_o | output | 1 | High while any change flag is set |

## Verification
The bench goes after these corner cases:

- **Ring edge direction.** A design that flags both ring edges would show bit 2 after a rising ring.
- **Change during a read.** A design that lets the read clear win would drop a change that lands in the same cycle as the read.
- **Synchronizer depth.** A change that appears one cycle early or late exposes a wrong stage count.
- **Loopback isolation.** Toggling the external lines and strobing reads inside loopback must leave the flags and levels untouched. Leaving loopback must then report the differences that built up.
- **Mixed stimulus.** A long pseudo-random run mixes all of the above, and the bench compares against its reference model every cycle.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int MCR_W       = 5;
    localparam int MCR_DTR     = 0;
    localparam int MCR_RTS     = 1;
    localparam int MCR_OUT1    = 2;
    localparam int MCR_OUT2    = 3;
    localparam int MCR_LOOP    = 4;
    localparam int LINE_N      = 4;
    localparam int BYTE_W      = 2 * LINE_N;
    localparam int SYNC_STAGES = 2;

    // Order sets bit position: dcd is the top bit, cts the bottom
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } msr_lines_t;

    localparam msr_lines_t LINES_IDLE = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};

    // Change flags between an old and a new sample; ring only on falling
    function automatic msr_lines_t edge_flags(msr_lines_t prev, msr_lines_t now);
        msr_lines_t f;
        f.dcd = prev.dcd ^ now.dcd;
        f.dsr = prev.dsr ^ now.dsr;
        f.cts = prev.cts ^ now.cts;
        f.ri  = prev.ri & ~now.ri;
        return f;
    endfunction

    // Status levels seen when control outputs are looped back
    function automatic msr_lines_t loop_map(logic [MCR_W-1:0] mcr);
        msr_lines_t l;
        l.dcd = mcr[MCR_OUT2];
        l.ri  = mcr[MCR_OUT1];
        l.dsr = mcr[MCR_DTR];
        l.cts = mcr[MCR_RTS];
        return l;
    endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/msr_delta_track.sv
module msr_delta_track
    import msr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frz_i,
    input  logic       clr_i,
    input  msr_lines_t smp_i,
    output msr_lines_t lvl_o,
    output msr_lines_t flg_o,
    output msr_lines_t chg_o
);
    msr_lines_t lvl_q, flg_q, chg;

    always_comb chg = frz_i ? '0 : edge_flags(lvl_q, smp_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= LINES_IDLE;
            flg_q <= '0;
        end else if (!frz_i) begin
            lvl_q <= smp_i;
            flg_q <= (clr_i ? msr_lines_t'('0) : flg_q) | chg;
        end
    end

    assign lvl_o = lvl_q;
    assign flg_o = flg_q;
    assign chg_o = chg;

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i || frz_i) |=> ((flg_q & $past(flg_q)) == $past(flg_q)));

    // R5
    ring_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flg_q.ri) |-> $fell(lvl_q.ri));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !frz_i && chg == '0) |=> (flg_q == '0));

    // R9
    loop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        frz_i |=> ($stable(lvl_q) && $stable(flg_q)));
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
    import msr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [MCR_W-1:0] mctl_i,
    input  logic             line_cts_i,
    input  logic             line_dsr_i,
    input  logic             line_dcd_i,
    input  logic             line_ri_i,
    input  logic             rd_stb_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic             delta_any_o
);
    msr_lines_t raw, synced, lvl, flg, chg;
    logic       loop_en;

    always_comb begin
        raw.dcd = line_dcd_i;
        raw.ri  = line_ri_i;
        raw.dsr = line_dsr_i;
        raw.cts = line_cts_i;
    end

    assign loop_en = mctl_i[MCR_LOOP];

    msr_sync #(
        .W       (LINE_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINES_IDLE)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (synced)
    );

    msr_delta_track trk_i (
        .clk   (clk),
        .rst   (rst),
        .frz_i (loop_en),
        .clr_i (rd_stb_i),
        .smp_i (synced),
        .lvl_o (lvl),
        .flg_o (flg),
        .chg_o (chg)
    );

    always_comb begin
        if (loop_en) rd_data_o = {loop_map(mctl_i), {LINE_N{1'b0}}};
        else         rd_data_o = {lvl, flg};
    end

    assign delta_any_o = |flg;

    // R10
    any_match_chk: assert property (@(posedge clk) disable iff (rst)
        !loop_en |-> (delta_any_o == (rd_data_o[LINE_N-1:0] != '0)));

    // R7
    read_vs_change_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb_i && !loop_en && chg != '0) |=> (delta_any_o == 1'b1));
endmodule

// File: tb/modem_status_tracker_tb.sv
module modem_status_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] mctl = 5'b0;
    logic [3:0] lines = 4'b1011; // {dcd, ri, dsr, cts}
    logic       rd = 1'b0;
    logic [7:0] rd_data;
    logic       delta_any;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    modem_status_tracker dut_i (
        .clk        (clk),
        .rst        (rst),
        .mctl_i     (mctl),
        .line_cts_i (lines[0]),
        .line_dsr_i (lines[1]),
        .line_dcd_i (lines[3]),
        .line_ri_i  (lines[2]),
        .rd_stb_i   (rd),
        .rd_data_o  (rd_data),
        .delta_any_o(delta_any)
    );

    // Reference model: two-edge delay queue, recorded levels and flags
    logic [3:0] pipe[$];
    logic [3:0] m_lvl = 4'b1011;
    logic [3:0] m_dlt = 4'b0000;

    always @(posedge clk) begin
        logic [3:0] seen, c;
        if (rst) begin
            pipe = {4'b1011, 4'b1011};
            m_lvl = 4'b1011;
            m_dlt = 4'b0000;
        end else begin
            seen = pipe.pop_front();
            pipe.push_back(lines);
            if (!mctl[4]) begin
                c[3] = seen[3] ^ m_lvl[3];
                c[2] = m_lvl[2] & ~seen[2];
                c[1] = seen[1] ^ m_lvl[1];
                c[0] = seen[0] ^ m_lvl[0];
                m_dlt = (rd ? 4'b0 : m_dlt) | c;
                m_lvl = seen;
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [7:0] e;
        e = mctl[4] ? {mctl[3], mctl[2], mctl[0], mctl[1], 4'b0} : {m_lvl, m_dlt};
        check(cur_req, rd_data, e);
        check("R10", {7'b0, delta_any}, {7'b0, |m_dlt});
    endtask

    task automatic step(input logic [3:0] ln, input logic [4:0] mc, input logic r, input string req);
        @(negedge clk);
        lines = ln; mctl = mc; rd = r; cur_req = req;
        #4;
        compare();
    endtask

    bit done = 0;
    initial begin
        #(1_000_000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #4;
        // R1: reset value
        check("R1", rd_data, 8'hB0);
        check("R1", {7'b0, delta_any}, 8'h00);
        repeat (3) step(4'b1011, 5'b0, 1'b0, "R1");

        // R3: clear-to-send drop, visible after third edge
        step(4'b1010, 5'b0, 1'b0, "R3");
        step(4'b1010, 5'b0, 1'b0, "R3");
        check("R3", rd_data, 8'hB0);
        step(4'b1010, 5'b0, 1'b0, "R3");
        check("R3", rd_data, 8'hB0);
        step(4'b1010, 5'b0, 1'b0, "R3");
        check("R3", rd_data, 8'hA1);

        // R4: line returns, flag stays
        repeat (4) step(4'b1011, 5'b0, 1'b0, "R4");
        check("R4", rd_data, 8'hB1);
        // R6: read then clear
        step(4'b1011, 5'b0, 1'b1, "R6");
        check("R6", rd_data, 8'hB1);
        step(4'b1011, 5'b0, 1'b0, "R6");
        check("R6", rd_data, 8'hB0);

        // R2/R4: carrier and data-set ready drop together
        repeat (4) step(4'b0001, 5'b0, 1'b0, "R2");
        check("R2", rd_data, 8'h1A);
        step(4'b0001, 5'b0, 1'b1, "R6");
        step(4'b0001, 5'b0, 1'b0, "R6");

        // R5: ring rises, no flag; ring falls, flag
        repeat (4) step(4'b0101, 5'b0, 1'b0, "R5");
        check("R5", rd_data, 8'h50);
        repeat (4) step(4'b0001, 5'b0, 1'b0, "R5");
        check("R5", rd_data, 8'h14);
        step(4'b0001, 5'b0, 1'b1, "R6");

        // R7: change lands in the read cycle
        step(4'b1001, 5'b0, 1'b0, "R7");
        step(4'b1001, 5'b0, 1'b0, "R7");
        step(4'b1001, 5'b0, 1'b1, "R7");
        step(4'b1001, 5'b0, 1'b0, "R7");
        check("R7", rd_data, 8'h98);

        // R8: loopback mapping
        step(4'b1001, 5'b10001, 1'b0, "R8");
        check("R8", rd_data, 8'h20);
        step(4'b1001, 5'b10010, 1'b0, "R8");
        check("R8", rd_data, 8'h10);
        step(4'b1001, 5'b10100, 1'b0, "R8");
        check("R8", rd_data, 8'h40);
        step(4'b1001, 5'b11000, 1'b0, "R8");
        check("R8", rd_data, 8'h80);
        // R9: lines and read ignored in loopback
        repeat (5) step(4'b0110, 5'b11111, 1'b1, "R9");
        check("R10", {7'b0, delta_any}, 8'h01);
        // leaving loopback surfaces the differences
        repeat (3) step(4'b0110, 5'b00000, 1'b0, "R9");
        check("R9", rd_data, 8'h6B);

        // mixed pseudo-random traffic
        lf = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[3:0], {(lf[11:8] == 4'hF), lf[7:4]}, lf[12] & lf[14], "R4");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule